// File: doc/BRIEF.md
# Status-Driven Two-Wire Message Sequencer

This block runs a single two-wire bus message on a byte-level bus controller with no software in the loop. A host presents a message descriptor and pulses `start`. The descriptor holds a 7-bit or 10-bit target address, a read/write direction, a flag that inverts the direction bit, a flag that skips the start and address phases, and a byte count. From then on, each time the controller raises its interrupt flag, the sequencer reads the controller's status code and decides the next step. It either loads the data register, rewrites the control register, or both.

Bytes to transmit come from a pull-style byte stream: `tx_byte` is consumed when `tx_take` pulses. Received bytes come out on `rx_byte` together with a one-cycle `rx_valid`. When the message ends, `done` pulses for one cycle and `result` holds one of four outcomes: success, no device, I/O error or timeout. A programmable cycle limit guards against a stalled bus. When the limit expires, the sequencer moves to an aborting state. In that state it forces a stop on the next flag, or gives up after a second expiry.

Top module: `xfer_seq`

## Requirements
- R1: After reset the block is idle (`busy`=0), `done`, `rx_valid`, `tx_take`, `ctl_data_we` and `ctl_ctrl_we` are 0.
- R2: A `start` pulse while idle, without the skip flag, writes control value 0xE4 and makes `busy` 1. Control bit positions are: ACK=2, FLAG=3, STOP=4, START=5, ENABLE=6, IRQ-enable=7, and the run value is 0xC4. A `start` while busy is ignored.
- R3: Status 0x08 or 0x10 writes the first address byte and then the run control value. In 7-bit mode that byte is {addr[6:0], dir}. In 10-bit mode it is 0xF0 | addr[9:8]<<1 | dir, where dir = read XOR reverse.
- R4: In 10-bit mode, status 0x18 or 0x40 writes addr[7:0] as the second address byte.
- R5: Status 0x18 (7-bit), 0xD0 or 0x28 sends the next stream byte (with `tx_take`) if bytes remain. Otherwise it stops with `done` and result 0 (success).
- R6: Status 0x40 (7-bit) or 0xE0 stops with success if the count is 0. Otherwise it rewrites control without touching the data register.
- R7: Status 0x50 outputs `ctl_rdata` on `rx_byte` with `rx_valid`. The ACK bit is cleared in every control write made while exactly one byte remains to be read.
- R8: Status 0x58 outputs the final byte, stops, and reports success.
- R9: Status 0x20, 0x30 or 0x48 stops with result 1 (no device). Any unlisted status stops with result 2 (I/O error).
- R10: Every stop write has STOP set and IRQ-enable cleared, for example 0x54, or 0x50 with ACK cleared.
- R11: With the skip flag set, a read start writes the run value (no START) and awaits data. A write start sends its first stream byte at once.
- R12: When `tmo_limit` (nonzero) cycles pass without completion, the block aborts. The next flag then gives a stop with result 3 (timeout). A second expiry ends the message with `done` and result 3 and makes no write. A limit of 0 disables the timeout.
- R13: A flag while idle produces a stop write without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a message (sampled while idle) |
| msg_addr | input | 10 | Target address |
| msg_ten | input | 1 | 10-bit address mode |
| msg_rd | input | 1 | Read direction |
| msg_rev | input | 1 | Invert direction bit |
| msg_skip | input | 1 | Skip start and address phases |
| msg_len | input | LEN_W | Byte count |
| tmo_limit | input | TO_W | Timeout in cycles, 0 disables |
| ctl_iflag | input | 1 | Controller interrupt flag |
| ctl_status | input | 8 | Controller status code |
| ctl_rdata | input | 8 | Controller received byte |
| ctl_wdata | output | 8 | Data register write value |
| ctl_data_we | output | 1 | Data register write strobe |
| ctl_ctrl | output | 8 | Control register write value |
| ctl_ctrl_we | output | 1 | Control register write strobe |
| tx_byte | input | 8 | Next byte to transmit |
| tx_take | output | 1 | Transmit byte consumed |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte strobe |
| busy | output | 1 | Message in progress |
| done | output | 1 | Message finished (one cycle) |
| result | output | 2 | 0 ok, 1 no device, 2 I/O error, 3 timeout |

## Verification
The status table is driven with sequences from a status-level controller model. The sequences cover a 7-bit write, a 7-bit read, a 10-bit write with the reverse flag, and a 10-bit single-byte read. Together they separate the address byte formats, the two address phases, and the point where ACK drops. Zero-length reads and writes confirm the early stop. Negative-acknowledge and unknown codes confirm the two error results. Skip-start messages in both directions, a flag while idle, and a start while busy exercise the paths away from the normal sequence. Single and double timeouts distinguish a forced stop from a silent give-up.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_WSTART, S_WADDR1, S_WADDR2, S_WACK, S_WDATA, S_ABORT
    } seq_state_e;

    localparam logic [1:0] RES_OK    = 2'd0;
    localparam logic [1:0] RES_NODEV = 2'd1;
    localparam logic [1:0] RES_IOERR = 2'd2;
    localparam logic [1:0] RES_TMO   = 2'd3;

    // control register bit positions, decoded by the controller
    localparam int CB_ACK   = 2;
    localparam int CB_FLAG  = 3;
    localparam int CB_STOP  = 4;
    localparam int CB_START = 5;
    localparam int CB_EN    = 6;
    localparam int CB_IEN   = 7;

    localparam logic [7:0] ST_START      = 8'h08;
    localparam logic [7:0] ST_RESTART    = 8'h10;
    localparam logic [7:0] ST_WADDR_ACK  = 8'h18;
    localparam logic [7:0] ST_WADDR_NACK = 8'h20;
    localparam logic [7:0] ST_WDATA_ACK  = 8'h28;
    localparam logic [7:0] ST_WDATA_NACK = 8'h30;
    localparam logic [7:0] ST_RADDR_ACK  = 8'h40;
    localparam logic [7:0] ST_RADDR_NACK = 8'h48;
    localparam logic [7:0] ST_RDATA_ACK  = 8'h50;
    localparam logic [7:0] ST_RDATA_NACK = 8'h58;
    localparam logic [7:0] ST_WADDR2_ACK = 8'hD0;
    localparam logic [7:0] ST_RADDR2_ACK = 8'hE0;

endpackage

// File: rtl/xseq_addr_fmt.sv
module xseq_addr_fmt (
    input  logic [9:0] addr,
    input  logic       ten,
    input  logic       rd,
    input  logic       rev,
    output logic [7:0] first,
    output logic [7:0] second
);
    logic dir;

    always_comb begin
        dir = rd ^ rev;
        if (ten) begin
            first  = 8'hF0 | {5'b0, addr[9:8], 1'b0} | {7'b0, dir};
            second = addr[7:0];
        end else begin
            first  = {addr[6:0], dir};
            second = 8'h00;
        end
    end
endmodule

// File: rtl/xseq_watch.sv
module xseq_watch #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [TO_W-1:0] limit,
    output logic            expire
);
    logic [TO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && (limit != '0) && (cnt_q == limit - 1'b1);
        if (!run || restart || expire) cnt_d = '0;
        else                           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R12
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0 && $stable(limit) && run) |-> (cnt_q < limit));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xseq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int TO_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [9:0]       msg_addr,
    input  logic             msg_ten,
    input  logic             msg_rd,
    input  logic             msg_rev,
    input  logic             msg_skip,
    input  logic [LEN_W-1:0] msg_len,
    input  logic [TO_W-1:0]  tmo_limit,
    input  logic             ctl_iflag,
    input  logic [7:0]       ctl_status,
    input  logic [7:0]       ctl_rdata,
    output logic [7:0]       ctl_wdata,
    output logic             ctl_data_we,
    output logic [7:0]       ctl_ctrl,
    output logic             ctl_ctrl_we,
    input  logic [7:0]       tx_byte,
    output logic             tx_take,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic             busy,
    output logic             done,
    output logic [1:0]       result
);
    localparam logic [7:0] CB_RUN = 8'((1 << CB_EN) | (1 << CB_IEN) | (1 << CB_ACK));
    localparam logic [7:0] CB_RST = 8'(1 << CB_EN);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        seq_state_e       st;
        logic [LEN_W-1:0] left;
        logic [7:0]       cb;
        logic [1:0]       res;
        logic             ten;
        logic [7:0]       a1;
        logic [7:0]       a2;
        logic [7:0]       wdata;
        logic             data_we;
        logic [7:0]       ctrl;
        logic             ctrl_we;
        logic             take;
        logic [7:0]       rxb;
        logic             rxv;
        logic             done;
        logic             gap;
    } seq_t;

    seq_t q, n;
    logic [7:0] fmt_a1, fmt_a2;
    logic       tmo_hit, tmo_restart, act;

    xseq_addr_fmt u_fmt (
        .addr(msg_addr), .ten(msg_ten), .rd(msg_rd), .rev(msg_rev),
        .first(fmt_a1), .second(fmt_a2)
    );

    xseq_watch #(.TO_W(TO_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .run(q.st != S_IDLE),
        .restart(tmo_restart), .limit(tmo_limit), .expire(tmo_hit)
    );

    function automatic seq_t f_ctrl(input seq_t s);
        s.ctrl    = s.cb;
        s.ctrl_we = 1'b1;
        s.gap     = 1'b1;
        return s;
    endfunction

    function automatic seq_t f_stop(input seq_t s);
        s.cb[CB_IEN] = 1'b0;
        s.ctrl       = s.cb | 8'(1 << CB_STOP);
        s.ctrl_we    = 1'b1;
        s.gap        = 1'b1;
        s.st         = S_IDLE;
        return s;
    endfunction

    function automatic seq_t f_finish(input seq_t s, input logic [1:0] code);
        s      = f_stop(s);
        s.res  = code;
        s.done = 1'b1;
        return s;
    endfunction

    function automatic seq_t f_send(input seq_t s, input logic [7:0] b);
        s.wdata   = b;
        s.data_we = 1'b1;
        return f_ctrl(s);
    endfunction

    function automatic seq_t f_wr_next(input seq_t s, input logic [7:0] b);
        if (s.left != '0) begin
            s      = f_send(s, b);
            s.take = 1'b1;
            s.left = s.left - 1'b1;
            s.st   = S_WACK;
        end else begin
            s = f_finish(s, s.res);
        end
        return s;
    endfunction

    function automatic seq_t f_rd_first(input seq_t s);
        if (s.left == '0) begin
            s = f_finish(s, s.res);
        end else begin
            if (s.left == ONE) s.cb[CB_ACK] = 1'b0;
            s    = f_ctrl(s);
            s.st = S_WDATA;
        end
        return s;
    endfunction

    function automatic seq_t f_addr2(input seq_t s);
        s    = f_send(s, s.a2);
        s.st = S_WADDR2;
        return s;
    endfunction

    always_comb begin
        n         = q;
        n.data_we = 1'b0;
        n.ctrl_we = 1'b0;
        n.take    = 1'b0;
        n.rxv     = 1'b0;
        n.done    = 1'b0;
        n.gap     = 1'b0;
        act       = ctl_iflag && !q.gap;

        if (q.st == S_IDLE) begin
            if (act) begin
                n = f_stop(n);
            end else if (start) begin
                n.a1   = fmt_a1;
                n.a2   = fmt_a2;
                n.ten  = msg_ten;
                n.left = msg_len;
                n.res  = RES_OK;
                n.cb   = CB_RUN;
                if (msg_skip && msg_rd) begin
                    n    = f_ctrl(n);
                    n.st = S_WDATA;
                end else if (msg_skip) begin
                    n      = f_send(n, tx_byte);
                    n.take = 1'b1;
                    n.left = msg_len - 1'b1;
                    n.st   = S_WACK;
                end else begin
                    n         = f_ctrl(n);
                    n.ctrl    = CB_RUN | 8'(1 << CB_START);
                    n.st      = S_WSTART;
                end
            end
        end else if (tmo_hit) begin
            if (q.st == S_ABORT) begin
                n.st   = S_IDLE;
                n.done = 1'b1;
            end else begin
                n.st  = S_ABORT;
                n.res = RES_TMO;
            end
        end else if (act) begin
            if (q.st == S_ABORT) begin
                n = f_finish(n, q.res);
            end else begin
                case (ctl_status)
                    ST_START, ST_RESTART: begin
                        n    = f_send(n, q.a1);
                        n.st = S_WADDR1;
                    end
                    ST_WADDR_ACK:
                        if (q.ten) n = f_addr2(n);
                        else       n = f_wr_next(n, tx_byte);
                    ST_WADDR2_ACK, ST_WDATA_ACK:
                        n = f_wr_next(n, tx_byte);
                    ST_RADDR_ACK:
                        if (q.ten) n = f_addr2(n);
                        else       n = f_rd_first(n);
                    ST_RADDR2_ACK:
                        n = f_rd_first(n);
                    ST_RDATA_ACK: begin
                        n.rxb  = ctl_rdata;
                        n.rxv  = 1'b1;
                        n.left = q.left - 1'b1;
                        if (n.left == ONE) n.cb[CB_ACK] = 1'b0;
                        n      = f_ctrl(n);
                        n.st   = S_WDATA;
                    end
                    ST_RDATA_NACK: begin
                        n.rxb = ctl_rdata;
                        n.rxv = 1'b1;
                        n     = f_finish(n, q.res);
                    end
                    ST_WADDR_NACK, ST_WDATA_NACK, ST_RADDR_NACK:
                        n = f_finish(n, RES_NODEV);
                    default:
                        n = f_finish(n, RES_IOERR);
                endcase
            end
        end
        tmo_restart = (n.st == S_ABORT) && (q.st != S_ABORT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.cb <= CB_RST;
        end else begin
            q <= n;
        end
    end

    assign ctl_wdata   = q.wdata;
    assign ctl_data_we = q.data_we;
    assign ctl_ctrl    = q.ctrl;
    assign ctl_ctrl_we = q.ctrl_we;
    assign tx_take     = q.take;
    assign rx_byte     = q.rxb;
    assign rx_valid    = q.rxv;
    assign busy        = (q.st != S_IDLE);
    assign done        = q.done;
    assign result      = q.res;

    // R10
    stop_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_ctrl_we && ctl_ctrl[CB_STOP]) |-> !ctl_ctrl[CB_IEN]);
    // R5
    take_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> ctl_data_we);
    // R7
    rx_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (ctl_ctrl_we && !ctl_ctrl[CB_START] && !ctl_data_we));
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R13
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R2
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_ctrl_we && ctl_ctrl[CB_START]) |-> ($past(start) && !$past(busy)));
endmodule

// File: tb/tb_xfer_seq.sv
`timescale 1ns/1ps
module tb_xfer_seq;
    localparam int LEN_W = 8;
    localparam int TO_W  = 16;
    localparam logic [7:0] C_RUN   = 8'hC4;
    localparam logic [7:0] C_START = 8'hE4;
    localparam logic [7:0] C_NOACK = 8'hC0;
    localparam logic [7:0] C_STOP  = 8'h54;
    localparam logic [7:0] C_STOPN = 8'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [9:0] msg_addr = '0;
    logic msg_ten = 1'b0, msg_rd = 1'b0, msg_rev = 1'b0, msg_skip = 1'b0;
    logic [LEN_W-1:0] msg_len = '0;
    logic [TO_W-1:0] tmo_limit = '0;
    logic ctl_iflag = 1'b0;
    logic [7:0] ctl_status = '0, ctl_rdata = '0, tx_byte = '0;
    logic [7:0] ctl_wdata, ctl_ctrl, rx_byte;
    logic ctl_data_we, ctl_ctrl_we, tx_take, rx_valid, busy, done;
    logic [1:0] result;

    int n_chk = 0;
    int n_bad = 0;

    logic       c_dwe, c_cwe, c_take, c_rxv, c_done;
    logic [7:0] c_wd, c_ctrl, c_rxb;
    logic [1:0] c_res;

    always #2 clk = ~clk;

    xfer_seq #(.LEN_W(LEN_W), .TO_W(TO_W)) dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic grab();
        c_dwe = ctl_data_we; c_wd = ctl_wdata; c_cwe = ctl_ctrl_we; c_ctrl = ctl_ctrl;
        c_take = tx_take; c_rxv = rx_valid; c_rxb = rx_byte; c_done = done; c_res = result;
    endtask

    task automatic kick(input logic [9:0] a, input logic ten, input logic rd, input logic rev,
                        input logic skip, input logic [7:0] len, input logic [7:0] txb);
        @(negedge clk);
        msg_addr = a; msg_ten = ten; msg_rd = rd; msg_rev = rev; msg_skip = skip;
        msg_len = len; tx_byte = txb; start = 1'b1;
        @(posedge clk); #1;
        grab();
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic step(input logic [7:0] st, input logic [7:0] rdat, input logic [7:0] txb);
        @(negedge clk);
        ctl_status = st; ctl_rdata = rdat; tx_byte = txb; ctl_iflag = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            if (ctl_ctrl_we || done) break;
        end
        grab();
        ctl_iflag = 1'b0;
    endtask

    task automatic t_write7();
        kick(10'h02A, 0, 0, 0, 0, 8'd2, 8'h00);
        check("R2 start ctrl", {c_cwe, c_ctrl}, {1'b1, C_START});
        check("R2 busy", busy, 1);
        step(8'h08, 0, 0);
        check("R3 7b write addr", {c_dwe, c_wd, c_ctrl}, {1'b1, 8'h54, C_RUN});
        step(8'h18, 0, 8'hA5);
        check("R5 byte0", {c_dwe, c_wd, c_take}, {1'b1, 8'hA5, 1'b1});
        step(8'h28, 0, 8'h3C);
        check("R5 byte1", {c_dwe, c_wd, c_take}, {1'b1, 8'h3C, 1'b1});
        step(8'h28, 0, 8'h99);
        check("R5 end stop", {c_take, c_dwe, c_ctrl, c_done, c_res}, {1'b0, 1'b0, C_STOP, 1'b1, 2'd0});
        check("R10 stop value", c_ctrl, C_STOP);
    endtask

    task automatic t_read7();
        tmo_limit = 0;
        kick(10'h051, 0, 1, 0, 0, 8'd2, 8'h00);
        repeat (100) @(negedge clk);
        check("R12 limit0 no abort", {busy, done}, 2'b10);
        step(8'h10, 0, 0);
        check("R3 7b read addr", {c_dwe, c_wd}, {1'b1, 8'hA3});
        step(8'h40, 0, 0);
        check("R6 resume no data", {c_dwe, c_cwe, c_ctrl, c_rxv}, {1'b0, 1'b1, C_RUN, 1'b0});
        step(8'h50, 8'h11, 0);
        check("R7 byte and ack drop", {c_rxv, c_rxb, c_ctrl}, {1'b1, 8'h11, C_NOACK});
        step(8'h58, 8'h22, 0);
        check("R8 last byte stop", {c_rxv, c_rxb, c_ctrl, c_done, c_res}, {1'b1, 8'h22, C_STOPN, 1'b1, 2'd0});
        tmo_limit = 16'd1000;
    endtask

    task automatic t_write10();
        kick(10'h2B7, 1, 0, 1, 0, 8'd1, 8'h00);
        step(8'h10, 0, 0);
        check("R3 10b first rev", c_wd, 8'hF5);
        step(8'h18, 0, 8'h77);
        check("R4 10b second", {c_dwe, c_wd, c_take}, {1'b1, 8'hB7, 1'b0});
        step(8'hD0, 0, 8'h77);
        check("R5 after addr2", {c_wd, c_take}, {8'h77, 1'b1});
        step(8'h28, 0, 0);
        check("R5 10b end", {c_done, c_res, c_ctrl}, {1'b1, 2'd0, C_STOP});
    endtask

    task automatic t_read10();
        kick(10'h155, 1, 1, 0, 0, 8'd1, 8'h00);
        step(8'h08, 0, 0);
        check("R3 10b read first", c_wd, 8'hF3);
        step(8'h40, 0, 0);
        check("R4 10b read second", {c_dwe, c_wd}, {1'b1, 8'h55});
        step(8'hE0, 0, 0);
        check("R7 single ack drop", {c_dwe, c_ctrl}, {1'b0, C_NOACK});
        step(8'h58, 8'h9E, 0);
        check("R8 single read", {c_rxv, c_rxb, c_done, c_ctrl}, {1'b1, 8'h9E, 1'b1, C_STOPN});
    endtask

    task automatic t_errors();
        kick(10'h033, 0, 0, 0, 0, 8'd3, 8'h00);
        step(8'h08, 0, 0);
        step(8'h20, 0, 0);
        check("R9 nodev", {c_done, c_res, c_ctrl}, {1'b1, 2'd1, C_STOP});
        kick(10'h033, 0, 0, 0, 0, 8'd3, 8'h00);
        step(8'h38, 0, 0);
        check("R9 ioerr", {c_done, c_res, c_ctrl}, {1'b1, 2'd2, C_STOP});
        kick(10'h033, 0, 1, 0, 0, 8'd0, 8'h00);
        step(8'h08, 0, 0);
        step(8'h40, 0, 0);
        check("R6 read len0", {c_done, c_res, c_rxv}, {1'b1, 2'd0, 1'b0});
        kick(10'h033, 0, 0, 0, 0, 8'd0, 8'h00);
        step(8'h08, 0, 0);
        step(8'h18, 0, 8'h12);
        check("R5 write len0", {c_done, c_take, c_dwe}, {1'b1, 1'b0, 1'b0});
    endtask

    task automatic t_skip();
        kick(10'h000, 0, 1, 0, 1, 8'd2, 8'h00);
        check("R11 skip read", {c_cwe, c_ctrl, c_dwe}, {1'b1, C_RUN, 1'b0});
        step(8'h50, 8'h61, 0);
        check("R11 skip read data", {c_rxv, c_rxb, c_ctrl}, {1'b1, 8'h61, C_NOACK});
        step(8'h58, 8'h62, 0);
        check("R8 skip read end", {c_done, c_rxb}, {1'b1, 8'h62});
        kick(10'h000, 0, 0, 0, 1, 8'd1, 8'hC7);
        check("R11 skip write", {c_dwe, c_wd, c_take, c_ctrl}, {1'b1, 8'hC7, 1'b1, C_RUN});
        step(8'h28, 0, 0);
        check("R11 skip write end", {c_done, c_res}, {1'b1, 2'd0});
    endtask

    task automatic t_timeout();
        tmo_limit = 16'd20;
        kick(10'h02A, 0, 0, 0, 0, 8'd1, 8'h00);
        repeat (30) @(negedge clk);
        check("R12 still busy", {busy, done}, 2'b10);
        step(8'h08, 0, 0);
        check("R12 forced stop", {c_done, c_res, c_dwe, c_ctrl}, {1'b1, 2'd3, 1'b0, C_STOP});
        tmo_limit = 16'd10;
        kick(10'h02A, 0, 0, 0, 0, 8'd1, 8'h00);
        begin
            int writes = 0;
            int seen = 0;
            logic [1:0] r = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (ctl_ctrl_we) writes++;
                if (done) begin seen++; r = result; end
            end
            check("R12 give up done", seen, 1);
            check("R12 give up result", r, 3);
            check("R12 give up no write", writes, 0);
            check("R12 idle after", busy, 0);
        end
        tmo_limit = 16'd1000;
    endtask

    task automatic t_idle_and_busy();
        step(8'h08, 0, 0);
        check("R13 idle flag stop", {c_cwe, c_ctrl[4], c_ctrl[7], c_done, busy}, 5'b11000);
        kick(10'h02A, 0, 0, 0, 0, 8'd1, 8'h00);
        @(negedge clk);
        msg_addr = 10'h010; msg_rd = 1; start = 1'b1;
        @(posedge clk); #1;
        check("R2 start while busy ignored", {ctl_ctrl_we, ctl_data_we}, 2'b00);
        @(negedge clk);
        start = 1'b0;
        step(8'h08, 0, 0);
        check("R2 descriptor kept", c_wd, 8'h54);
        step(8'h20, 0, 0);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tmo_limit = 16'd1000;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {busy, done, rx_valid, tx_take, ctl_data_we, ctl_ctrl_we}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {busy, done, ctl_ctrl_we}, 3'b0);
        t_write7();
        t_read7();
        t_write10();
        t_read10();
        t_errors();
        t_skip();
        t_timeout();
        t_idle_and_busy();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule